// File: doc/BRIEF.md
# Parallel Frame Scrambler

The block whitens converter sample words ahead of an 8B/10B encoder. Each 16-bit frame is scrambled in a single clock with a self-synchronous sequence built on the polynomial 1 + x^14 + x^15. Every output bit is the input bit XORed with the scrambled bits that came out 14 and 15 bit-times earlier. The most significant input bit counts as the earliest bit of the serial stream. The scrambled frame is registered and presented as two octets, and the earlier octet goes to code group 1.

A static enable selects between scrambling and plain pass-through. A frame strobe marks the cycles that carry a sample. Only strobed, enabled frames advance the 15-bit history, and the history is cleared by reset. A receiver built on the same polynomial therefore aligns itself after 15 bits.

Top module: `frame_scrambler`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o is 0 and both octet outputs are 0. The history starts at zero, so an all-ones first frame yields 0xFFFD.
- R2: With scram_en_i high, output bit s[n] = d[n] XOR s[n-14] XOR s[n-15]. Within a frame, data_i bit 15 is bit n=0 and bit 0 is bit n=15, and the history carries over from one frame to the next.
- R3: cg1_o carries result bits 15:8, which are the earlier half. cg2_o carries bits 7:0.
- R4: The result appears one clock after the strobed input. valid_o equals valid_i delayed by one clock.
- R5: With scram_en_i low, a strobed frame leaves the block unchanged: {cg1_o,cg2_o} equals data_i.
- R6: Frames strobed while scram_en_i is low do not advance the history, so the next enabled frame continues the sequence as if they had not occurred.
- R7: In cycles with valid_i low, the octet outputs and the history hold, whatever data_i carries.
- R8: With zero history, an all-zero enabled frame produces an all-zero result.
- R9: After a single-bit seed, all-zero enabled input produces an output stream that repeats with period 2^15-1 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scram_en_i | input | 1 | 1 = scramble, 0 = pass-through |
| valid_i | input | 1 | Frame strobe |
| data_i | input | 16 | Sample word; bit 15 is earliest |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| cg1_o | output | 8 | Earlier octet (result bits 15:8) |
| cg2_o | output | 8 | Later octet (result bits 7:0) |

## Verification
The bench uses the default values: a 16-bit frame with taps at 14 and 15. Under these values the last two bits of each frame depend on bits of the same frame, and the first fourteen bits depend only on the previous frame, so both paths of the unrolled logic are exercised. A 15-bit history keeps the full 32767-bit period short enough to run to completion. The bench then confirms that this period repeats.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned FRAME_W_DEF  = 16;
  localparam int unsigned TAP_NEAR_DEF = 14;
  localparam int unsigned TAP_FAR_DEF  = 15;
endpackage

// File: rtl/scr_core.sv
module scr_core #(
  parameter int unsigned FRAME_W  = scr_pkg::FRAME_W_DEF,
  parameter int unsigned TAP_NEAR = scr_pkg::TAP_NEAR_DEF,
  parameter int unsigned TAP_FAR  = scr_pkg::TAP_FAR_DEF
) (
  input  logic [TAP_FAR-1:0] hist_i,   // [0] oldest, [TAP_FAR-1] newest
  input  logic [FRAME_W-1:0] data_i,   // MSB earliest
  output logic [FRAME_W-1:0] scr_o,
  output logic [TAP_FAR-1:0] hist_nxt_o
);
  localparam int unsigned EXT_W = TAP_FAR + FRAME_W;

  function automatic logic [EXT_W-1:0] unroll(input logic [TAP_FAR-1:0] h,
                                              input logic [FRAME_W-1:0] d);
    logic [EXT_W-1:0] e;
    e = '0;
    for (int i = 0; i < int'(TAP_FAR); i++) e[i] = h[i];
    for (int k = 0; k < int'(FRAME_W); k++)
      e[int'(TAP_FAR)+k] = d[int'(FRAME_W)-1-k]
                         ^ e[int'(TAP_FAR)+k-int'(TAP_NEAR)]
                         ^ e[k];
    return e;
  endfunction

  logic [EXT_W-1:0] ext;

  always_comb begin
    ext = unroll(hist_i, data_i);
    for (int k = 0; k < int'(FRAME_W); k++)
      scr_o[int'(FRAME_W)-1-k] = ext[int'(TAP_FAR)+k];
    hist_nxt_o = ext[EXT_W-1 -: TAP_FAR];
  end
endmodule

// File: rtl/scr_state.sv
module scr_state #(
  parameter int unsigned TAP_FAR = scr_pkg::TAP_FAR_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic [TAP_FAR-1:0] hist_nxt_i,
  output logic [TAP_FAR-1:0] hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_o <= '0;
    else if (adv_i) hist_o <= hist_nxt_i;
  end

  assert_hist_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(hist_o));
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int unsigned FRAME_W = scr_pkg::FRAME_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               scram_en_i,
  input  logic [FRAME_W-1:0] plain_i,
  input  logic [FRAME_W-1:0] scr_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      frame_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) frame_o <= scram_en_i ? scr_i : plain_i;
    end
  end

  assert_valid_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !scram_en_i) |=> frame_o == $past(plain_i));
  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(frame_o));
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler #(
  parameter int unsigned FRAME_W  = scr_pkg::FRAME_W_DEF,
  parameter int unsigned TAP_NEAR = scr_pkg::TAP_NEAR_DEF,
  parameter int unsigned TAP_FAR  = scr_pkg::TAP_FAR_DEF,
  localparam int unsigned HALF_W  = FRAME_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scram_en_i,
  input  logic               valid_i,
  input  logic [FRAME_W-1:0] data_i,
  output logic               valid_o,
  output logic [HALF_W-1:0]  cg1_o,
  output logic [HALF_W-1:0]  cg2_o
);
  logic [TAP_FAR-1:0] hist_q, hist_nxt;
  logic [FRAME_W-1:0] scr, frame_q;
  logic               adv;

  assign adv = valid_i & scram_en_i;

  scr_core #(.FRAME_W(FRAME_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_core (
    .hist_i(hist_q), .data_i(data_i), .scr_o(scr), .hist_nxt_o(hist_nxt));

  scr_state #(.TAP_FAR(TAP_FAR)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv),
    .hist_nxt_i(hist_nxt), .hist_o(hist_q));

  scr_out_stage #(.FRAME_W(FRAME_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .scram_en_i(scram_en_i),
    .plain_i(data_i), .scr_i(scr), .valid_o(valid_o), .frame_o(frame_q));

  assign cg1_o = frame_q[FRAME_W-1 -: HALF_W];
  assign cg2_o = frame_q[HALF_W-1:0];

  assert_zero_in_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && hist_q == '0 && data_i == '0) |=> {cg1_o, cg2_o} == '0);
  assert_no_adv_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !scram_en_i) |=> $stable(hist_q));
endmodule

// File: tb/frame_scrambler_tb.sv
module frame_scrambler_tb;
  localparam int CLK_P = 10;
  localparam int NVEC  = 12;
  // {scram_en, data}; expected comes from the serial model
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {1'b1,16'h1234}, {1'b1,16'hA5A5}, {1'b1,16'h0000}, {1'b1,16'hFFFF},
    {1'b0,16'hBEEF}, {1'b1,16'h8001}, {1'b1,16'h7FFE}, {1'b0,16'h0F0F},
    {1'b1,16'hC3C3}, {1'b1,16'h0001}, {1'b1,16'h8000}, {1'b1,16'h5555}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0, scram_en_i = 1'b0, valid_i = 1'b0;
  logic [15:0] data_i = '0;
  logic valid_o;
  logic [7:0] cg1_o, cg2_o;
  int n_chk = 0, n_err = 0;
  logic [14:0] mh = '0;   // [0] newest, [13] 14 back, [14] 15 back
  logic pb [0:32799];
  int pn = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_scrambler u_dut (.clk_i(clk), .rst_ni(rst_ni), .scram_en_i(scram_en_i),
    .valid_i(valid_i), .data_i(data_i), .valid_o(valid_o), .cg1_o(cg1_o), .cg2_o(cg2_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic en, input logic [15:0] d, output logic [15:0] e);
    logic s;
    if (!en) e = d;
    else for (int k = 15; k >= 0; k--) begin
      s = d[k] ^ mh[13] ^ mh[14];
      e[k] = s;
      mh = {mh[13:0], s};
    end
  endtask

  task automatic send(input string req, input logic en, input logic [15:0] d,
                      output logic [15:0] got);
    logic [15:0] e;
    @(negedge clk);
    scram_en_i = en; data_i = d; valid_i = 1'b1;
    model(en, d, e);
    @(negedge clk);
    got = {cg1_o, cg2_o};
    check({req, " valid R4"}, {31'd0, valid_o}, 32'd1);
    check(req, {16'd0, got}, {16'd0, e});
    valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0;
    mh = '0;
    @(negedge clk);
    check("R1 valid in reset", {31'd0, valid_o}, 32'd0);
    check("R1 octets in reset", {16'd0, cg1_o, cg2_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 octets after reset", {16'd0, cg1_o, cg2_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] got, held;
    int mis;
    do_reset();
    // R1 R2: all-ones frame from zero history, hand value
    send("R1 R2 first frame", 1'b1, 16'hFFFF, got);
    check("R3 cg1 earlier octet", {24'd0, cg1_o}, 32'hFF);
    check("R3 cg2 later octet", {24'd0, cg2_o}, 32'hFD);

    // vector walk: R2 R5 R6
    for (int i = 0; i < NVEC; i++)
      send("R2 R5 R6 vector", VEC[i][16], VEC[i][15:0], got);

    // R7: idle cycles with junk data hold outputs and history
    held = {cg1_o, cg2_o};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      data_i = 16'hDEAD ^ 16'(i); scram_en_i = 1'b1;
      @(negedge clk);
      check("R7 octets hold", {16'd0, cg1_o, cg2_o}, {16'd0, held});
      check("R4 valid low", {31'd0, valid_o}, 32'd0);
    end
    send("R7 history held", 1'b1, 16'h3C5A, got);

    // R6: disabled frames then resume
    send("R5 bypass", 1'b0, 16'h1111, got);
    send("R5 bypass", 1'b0, 16'hFFFF, got);
    send("R6 resume", 1'b1, 16'h0000, got);

    // R8: zero in, zero history
    do_reset();
    send("R8 zero", 1'b1, 16'h0000, got);
    send("R8 zero", 1'b1, 16'h0000, got);

    // R9: period after single-bit seed
    do_reset();
    send("R9 seed", 1'b1, 16'h8000, got);
    for (int k = 15; k >= 0; k--) begin pb[pn] = got[k]; pn++; end
    for (int f = 0; f < 2049; f++) begin
      send("R9 run", 1'b1, 16'h0000, got);
      for (int k = 15; k >= 0; k--) begin pb[pn] = got[k]; pn++; end
    end
    mis = 0;
    for (int n = 0; n < 33; n++) if (pb[n] !== pb[n+32767]) mis++;
    check("R9 period 32767", mis, 0);
    mis = 0;
    for (int n = 0; n < 33; n++) if (pb[n] !== pb[n+16383]) mis++;
    check("R9 not half period", {31'd0, mis != 0}, 32'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule